// File: doc/BRIEF.md
# Single-Button Centisecond Stopwatch Controller

This block measures elapsed time in hundredths of a second, controlled by one mechanical push button and an asynchronous reset. The raw button level is synchronised and filtered against contact chatter. Each clean press becomes exactly one single-cycle event. Successive events move a small controller from waiting, to counting, to frozen, and back to a cleared wait.

The elapsed time is held as four BCD digits in seconds-and-hundredths form, from 00.00 up to 59.99. A hundredths step past 59.99 does not wrap. Instead the block enters an overflow state, in which every digit carries a reserved dash code. A later press leaves that state. The outputs are the four digit codes, a one-hot decimal-point position and an overflow flag. A separate four-digit seven-segment scanner consumes them.

The bounce filter length and the hundredths divisor are parameters. Their defaults suit a 100 MHz clock: 60 ms of stable level, and 10 ms per hundredth. A simulation can shrink both without changing the behaviour.

Top module: `chrono_btn_ctrl`

## Requirements
- R1: Asserting `rst_i` immediately, without waiting for a clock edge, forces `digits_o` to 16'h0000 and `ovf_o` to 0, and leaves the block waiting for a start press.
- R2: Button events cycle the controller waiting → counting → frozen → waiting. The step from frozen to waiting clears the digits to 00.00, and they stay zero while waiting.
- R3: While counting, the value advances by exactly one hundredth every `TICK_DIV` clock cycles.
- R4: `digits_o[3:0]` holds hundredths units and `digits_o[7:4]` hundredths tens, each 0 to 9. `digits_o[11:8]` holds seconds units (0 to 9) and `digits_o[15:12]` seconds tens (0 to 5). A hundredths step at x.99 carries into the seconds.
- R5: While frozen, the digits do not change.
- R6: A new button level is accepted only after it has been stable for `STABLE_CYC` consecutive cycles. Shorter pulses and chatter are ignored. One press, including its bounce, gives exactly one event, on the accepted rising level.
- R7: A hundredths step at 59.99 sets `ovf_o` to 1, and every nibble of `digits_o` becomes the dash code 4'hA. This holds until the next event.
- R8: A press while in overflow returns the block to 00.00, clears `ovf_o` and waits; it does not start counting.
- R9: `dp_sel_o` is 4'b0100 at all times. This places the point on the seconds-units digit, between SS and DD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous active-high reset |
| btn_i | input | 1 | Raw, unsynchronised start/stop/clear button, active high |
| digits_o | output | 16 | Four digit codes: BCD, or 4'hA for dash |
| dp_sel_o | output | 4 | One-hot decimal-point digit select |
| ovf_o | output | 1 | High while in the overflow state |

## Verification
A change on `btn_i` needs two synchroniser cycles plus `STABLE_CYC` cycles to raise the event. The controller state moves one cycle later. The first hundredth then appears `TICK_DIV` + 1 cycles after that. Because exact press alignment is awkward to predict, the bench never samples a count at a guessed absolute cycle. It waits well past the event latency before judging a state change, and it measures counting rate as the difference between two samples taken a whole number of `TICK_DIV` periods apart. Reset is judged between clock edges, and every sample is taken on the falling edge.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int unsigned NDIG = 4;
  localparam logic [3:0] DASH_CODE = 4'hA;
  localparam logic [NDIG-1:0] DP_ONEHOT = 4'b0100;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2,
    ST_OVF  = 2'd3
  } sw_state_t;
endpackage

// File: rtl/btn_filter.sv
module btn_filter #(
  parameter int unsigned STABLE_CYC = 6_000_000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic raw_i,
  output logic press_o
);
  localparam int unsigned CW = $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(STABLE_CYC - 1);

  logic         sync1_q, sync2_q, level_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      level_q <= 1'b0;
      run_q   <= '0;
      press_o <= 1'b0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
      press_o <= 1'b0;
      if (sync2_q == level_q) begin
        run_q <= '0;
      end else if (run_q == LIM) begin
        level_q <= sync2_q;
        run_q   <= '0;
        press_o <= sync2_q;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int unsigned TICK_DIV = 1_000_000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(TICK_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bcd_timer.sv
module bcd_timer
  import sw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [4*NDIG-1:0] dig_o,
  output logic              carry_o
);
  logic [NDIG:0]   inc;
  logic [NDIG-1:0] at_top;

  assign inc[0]  = step_i;
  assign carry_o = inc[NDIG];

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    localparam logic [3:0] TOPV = (i == NDIG - 1) ? 4'd5 : 4'd9;
    logic [3:0] d_q;

    assign at_top[i]      = (d_q == TOPV);
    assign inc[i+1]       = inc[i] & at_top[i];
    assign dig_o[4*i +: 4] = d_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)                  d_q <= 4'd0;
      else if (clr_i)             d_q <= 4'd0;
      else if (inc[i] && !inc[NDIG])
        d_q <= at_top[i] ? 4'd0 : d_q + 4'd1;
    end
  end
endmodule

// File: rtl/chrono_btn_ctrl.sv
module chrono_btn_ctrl
  import sw_pkg::*;
#(
  parameter int unsigned STABLE_CYC = 6_000_000,
  parameter int unsigned TICK_DIV   = 1_000_000
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        btn_i,
  output logic [15:0] digits_o,
  output logic [3:0]  dp_sel_o,
  output logic        ovf_o
);
  sw_state_t   state_q, state_d;
  logic        press_evt, tick_w, carry_w, step_w, clr_w;
  logic [15:0] tmr_dig;

  btn_filter #(.STABLE_CYC(STABLE_CYC)) u_filt (
    .clk_i(clk_i), .rst_i(rst_i), .raw_i(btn_i), .press_o(press_evt)
  );

  tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(state_q == ST_RUN), .tick_o(tick_w)
  );

  assign step_w = tick_w && (state_q == ST_RUN);

  bcd_timer u_tmr (
    .clk_i(clk_i), .rst_i(rst_i), .clr_i(clr_w), .step_i(step_w),
    .dig_o(tmr_dig), .carry_o(carry_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT: if (press_evt) state_d = ST_RUN;
      ST_RUN: begin
        if (carry_w)        state_d = ST_OVF;
        else if (press_evt) state_d = ST_HOLD;
      end
      ST_HOLD: if (press_evt) state_d = ST_WAIT;
      ST_OVF:  if (press_evt) state_d = ST_WAIT;
      default: state_d = ST_WAIT;
    endcase
  end

  assign clr_w = (state_d == ST_WAIT) && (state_q != ST_WAIT);

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) state_q <= ST_WAIT;
    else       state_q <= state_d;
  end

  assign ovf_o    = (state_q == ST_OVF);
  assign digits_o = ovf_o ? {NDIG{DASH_CODE}} : tmr_dig;
  assign dp_sel_o = DP_ONEHOT;
endmodule

// File: rtl/chrono_btn_ctrl_chk.sv
module chrono_btn_ctrl_chk
  import sw_pkg::*;
(
  input logic        clk_i,
  input logic        rst_i,
  input sw_state_t   state,
  input logic        press,
  input logic        tick,
  input logic [15:0] tmr,
  input logic [15:0] digits_o,
  input logic        ovf_o
);
  assert_bcd_range_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !ovf_o |-> (digits_o[3:0] <= 4'd9 && digits_o[7:4] <= 4'd9 &&
                digits_o[11:8] <= 4'd9 && digits_o[15:12] <= 4'd5));

  assert_dash_show_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    ovf_o |-> (digits_o == 16'hAAAA && tmr == 16'h5999));

  assert_hold_freeze_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (state == ST_HOLD && !press) |=> $stable(digits_o));

  assert_tick_step_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (state == ST_RUN && tick) |=> (digits_o != $past(digits_o)));

  assert_wait_zero_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (state == ST_WAIT && $past(state) == ST_WAIT) |-> digits_o == 16'h0000);

  assert_single_event_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    press |=> !press);

  assert_ovf_leave_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (state == ST_OVF && press) |=> (state == ST_WAIT));
endmodule

bind chrono_btn_ctrl chrono_btn_ctrl_chk chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .state(state_q), .press(press_evt),
  .tick(tick_w), .tmr(tmr_dig), .digits_o(digits_o), .ovf_o(ovf_o)
);

// File: tb/chrono_btn_ctrl_tb_top.sv
`timescale 1ns/1ps
module chrono_btn_ctrl_tb_top;
  localparam int STB = 20;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic [15:0] digits;
  logic [3:0]  dp_sel;
  logic        ovf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  chrono_btn_ctrl #(.STABLE_CYC(STB), .TICK_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_i(rst), .btn_i(btn),
    .digits_o(digits), .dp_sel_o(dp_sel), .ovf_o(ovf)
  );

  function automatic int bcd2int(logic [15:0] d);
    return int'(d[15:12]) * 1000 + int'(d[11:8]) * 100 +
           int'(d[7:4]) * 10 + int'(d[3:0]);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press_btn();
    btn = 1; cyc(2); btn = 0; cyc(3); btn = 1; cyc(1); btn = 0; cyc(2);
    btn = 1; cyc(STB + 12);
    btn = 0; cyc(2); btn = 1; cyc(2); btn = 0; cyc(STB + 12);
  endtask

  task automatic t_reset();
    rst = 1; btn = 0; cyc(4); rst = 0; cyc(2);
    check(digits == 16'h0000, "R1", "digits after reset", digits, 0);
    check(ovf == 1'b0, "R1", "ovf after reset", ovf, 0);
    check(dp_sel == 4'b0100, "R9", "point position", dp_sel, 4'b0100);
  endtask

  task automatic t_glitch();
    btn = 1; cyc(STB - 6); btn = 0; cyc(100);
    check(digits == 16'h0000, "R6", "short pulse ignored", digits, 0);
  endtask

  task automatic t_start_rate();
    int a, b;
    press_btn();
    a = bcd2int(digits);
    cyc(40 * DIV);
    b = bcd2int(digits);
    check(b - a == 40, "R3", "hundredths per 40 periods", b - a, 40);
    check(a > 0, "R6", "bouncy press gave one start", a, 1);
  endtask

  task automatic t_hold();
    int a, b;
    press_btn();
    a = bcd2int(digits);
    cyc(200);
    b = bcd2int(digits);
    check(a == b, "R5", "frozen value", b, a);
    check(a > 0, "R2", "hold keeps nonzero time", a, 1);
  endtask

  task automatic t_clear();
    press_btn();
    check(digits == 16'h0000, "R2", "cleared digits", digits, 0);
    cyc(200);
    check(digits == 16'h0000, "R2", "waiting after clear", digits, 0);
  endtask

  task automatic t_carry();
    int a, b, guard;
    logic [15:0] d;
    press_btn();
    guard = 0;
    while (bcd2int(digits) < 80 && guard < 2000) begin cyc(1); guard++; end
    a = bcd2int(digits);
    cyc(40 * DIV);
    d = digits;
    b = bcd2int(d);
    check(b - a == 40, "R4", "count across carry", b - a, 40);
    check(d[11:8] == 4'd1 && d[7:4] <= 4'd9, "R4", "seconds after carry", d, 16'h0120);
    press_btn(); press_btn();
  endtask

  task automatic t_ovf();
    int guard;
    press_btn();
    guard = 0;
    while (bcd2int(digits) < 5990 && guard < 30000) begin cyc(1); guard++; end
    check(digits[15:12] == 4'd5 && digits[11:8] == 4'd9, "R4", "seconds reach 59",
          digits, 16'h5990);
    guard = 0;
    while (!ovf && guard < 200) begin cyc(1); guard++; end
    check(ovf == 1'b1, "R7", "overflow flag", ovf, 1);
    check(digits == 16'hAAAA, "R7", "dash codes", digits, 16'hAAAA);
    cyc(200);
    check(ovf == 1'b1 && digits == 16'hAAAA, "R7", "overflow held", digits, 16'hAAAA);
    check(dp_sel == 4'b0100, "R9", "point in overflow", dp_sel, 4'b0100);
    press_btn();
    check(ovf == 1'b0 && digits == 16'h0000, "R8", "cleared from overflow", digits, 0);
    cyc(200);
    check(digits == 16'h0000, "R8", "no restart after overflow", digits, 0);
  endtask

  task automatic t_async();
    press_btn();
    cyc(100);
    check(digits != 16'h0000, "R1", "running before reset", digits, 1);
    #1 rst = 1;
    #0.5;
    check(digits == 16'h0000 && ovf == 1'b0, "R1", "async clear between edges", digits, 0);
    cyc(3); rst = 0; cyc(200);
    check(digits == 16'h0000, "R1", "waiting after reset", digits, 0);
  endtask

  initial begin
    t_reset();
    t_glitch();
    t_start_rate();
    t_hold();
    t_clear();
    t_carry();
    t_ovf();
    t_async();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule